// File: doc/BRIEF.md
# Pipelined Random Event Time Generator

This block produces a stream of simulation arrival events, one per clock once its pipeline has filled. Each event carries an arrival time, a finish time and two small resource demands. A free-running linear feedback shift register supplies one uniform random word per event. Two lanes use that word at the same time. One lane turns the word's top byte into an exponentially distributed gap, using a negative-logarithm lookup and a multiply by a runtime mean. The other lane scales the word's low half into a uniform service duration.

The only state that carries from one event to the next is the running arrival time. Each new gap is added to it, and the sum saturates at the largest representable time. The finish time is that arrival plus the event's service duration. The event is offered on a valid/ready port toward a downstream queue. When the queue is not ready, every stage of the pipeline and the random source freeze together, so no event is skipped or repeated.

Times are 24-bit unsigned fixed point with 8 fractional bits. The rate inputs are 16-bit values with 8 fractional bits, and they should be held steady while events are in flight.

Top module: `rand_event_gen`

## Requirements
- R1: A synchronous reset drops `out_valid`, clears the arrival accumulator to zero and reloads the random register with 0xACE12468, so the event sequence after every reset is identical for identical rate inputs.
- R2: The random register is a 32-bit right-shifting Galois LFSR. When bit 0 is 1, the next state is (state >> 1) XOR 0x80200003; otherwise it is state >> 1. It steps once per pipeline advance, and event k (counting from 0 after reset) is built from state k.
- R3: The arrival gap is (mean_gap × NL(i)) >> 8. Here i is bits 31:24 of the random word and NL(i) = floor(−ln(i/256)·256 + 0.5). An index of 0 uses NL(1) in its place.
- R4: Each arrival time is the previous event's arrival time plus the new gap, starting from zero after reset. It saturates at 0xFFFFFF instead of wrapping.
- R5: The service offset is (bits 15:0 of the random word × svc_span) >> 16. The finish time is the event's arrival time plus its service offset, saturating at 0xFFFFFF.
- R6: `out_need_a` is bits 23:20 and `out_need_b` is bits 19:16 of the event's random word.
- R7: `out_valid` first rises after the third clock edge that follows reset release. With `out_ready` held high, one event is accepted on every clock from then on.
- R8: While `out_valid` is high and `out_ready` is low, every output holds its value. Accepted events appear in generation order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mean_gap | input | 16 | Mean arrival gap, 8 fractional bits |
| svc_span | input | 16 | Upper bound of the service offset, 8 fractional bits |
| out_valid | output | 1 | An event is offered |
| out_ready | input | 1 | Downstream accepts the offered event |
| out_arrival | output | 24 | Arrival time, 8 fractional bits |
| out_finish | output | 24 | Finish time, 8 fractional bits |
| out_need_a | output | 4 | Demand on the first resource |
| out_need_b | output | 4 | Demand on the second resource |

## Verification
Back-pressure and saturation of the arrival accumulator can occur in the same cycle. When that happens, the accumulator must freeze at its ceiling while the saturated event is held on the output. The bench provokes this with the largest mean gap and a pseudo-random ready pattern that is low about half the time. Several hundred events are run, well past the point where the arrival time pins at 0xFFFFFF. A scoreboard model computes every event in order from the stated formulas and compares each accepted event, so a stall that drops, repeats or changes a saturated event shows up as a miscompare.

// File: rtl/evgen_pkg.sv
package evgen_pkg;
    localparam int TIME_W   = 24;
    localparam int FRAC_W   = 8;
    localparam int RATE_W   = 16;
    localparam int LN_IDX_W = 8;
    localparam int LN_W     = 12;
    localparam int RES_W    = 4;
    localparam int RND_W    = 32;
    localparam logic [RND_W-1:0] LFSR_TAPS = 32'h8020_0003;
    localparam logic [RND_W-1:0] LFSR_SEED = 32'hACE1_2468;

    // rounded -ln(k / 2^idx_w) scaled by 2^frac_w; index 0 borrows index 1
    function automatic int neglog_fx(int idx, int idx_w, int frac_w);
        int  k;
        real u;
        real v;
        k = (idx == 0) ? 1 : idx;
        u = real'(k) / real'(2 ** idx_w);
        v = -$ln(u) * real'(2 ** frac_w);
        return $rtoi(v + 0.5);
    endfunction
endpackage

// File: rtl/evgen_lfsr.sv
module evgen_lfsr #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    TAPS = 32'h8020_0003,
    parameter logic [W-1:0]    SEED = 32'hACE1_2468
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (step) begin
            state <= state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);
        end
    end
endmodule

// File: rtl/evgen_neglog_rom.sv
module evgen_neglog_rom #(
    parameter int IDX_W  = 8,
    parameter int OUT_W  = 12,
    parameter int FRAC_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [OUT_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign tbl[i] = OUT_W'(evgen_pkg::neglog_fx(i, IDX_W, FRAC_W));
    end

    assign val = tbl[idx];
endmodule

// File: rtl/evgen_sat_add.sv
module evgen_sat_add #(
    parameter int W  = 24,
    parameter int BW = 20
) (
    input  logic [W-1:0]  a,
    input  logic [BW-1:0] b,
    output logic [W-1:0]  sum
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + (W+1)'(b);
        sum  = full[W] ? '1 : full[W-1:0];
    end
endmodule

// File: rtl/rand_event_gen.sv
module rand_event_gen #(
    parameter int TIME_W   = evgen_pkg::TIME_W,
    parameter int FRAC_W   = evgen_pkg::FRAC_W,
    parameter int RATE_W   = evgen_pkg::RATE_W,
    parameter int LN_IDX_W = evgen_pkg::LN_IDX_W,
    parameter int LN_W     = evgen_pkg::LN_W,
    parameter int RES_W    = evgen_pkg::RES_W,
    parameter int RND_W    = evgen_pkg::RND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] mean_gap,
    input  logic [RATE_W-1:0] svc_span,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TIME_W-1:0] out_arrival,
    output logic [TIME_W-1:0] out_finish,
    output logic [RES_W-1:0]  out_need_a,
    output logic [RES_W-1:0]  out_need_b
);
    localparam int GPROD_W = RATE_W + LN_W;
    localparam int GAP_W   = GPROD_W - FRAC_W;
    localparam int SPROD_W = 2 * RATE_W;
    localparam int RA_HI   = RND_W - LN_IDX_W - 1;
    localparam int RB_HI   = RA_HI - RES_W;

    // pipeline advance: every stage and the random source move together
    logic adv;
    assign adv = !out_valid || out_ready;

    // random source
    logic [RND_W-1:0] rnd;
    evgen_lfsr #(
        .W   (RND_W),
        .TAPS(evgen_pkg::LFSR_TAPS),
        .SEED(evgen_pkg::LFSR_SEED)
    ) u_lfsr (
        .clk  (clk),
        .rst  (rst),
        .step (adv),
        .state(rnd)
    );

    // lane 1: negative log of the uniform top byte
    logic [LN_W-1:0] nl_cur;
    evgen_neglog_rom #(
        .IDX_W (LN_IDX_W),
        .OUT_W (LN_W),
        .FRAC_W(FRAC_W)
    ) u_rom (
        .idx(rnd[RND_W-1 -: LN_IDX_W]),
        .val(nl_cur)
    );

    // lane 2: uniform service offset
    logic [SPROD_W-1:0] svc_prod;
    assign svc_prod = SPROD_W'(rnd[RATE_W-1:0]) * SPROD_W'(svc_span);

    // stage A: offsets created
    logic              a_v;
    logic [LN_W-1:0]   a_nl;
    logic [RATE_W-1:0] a_svc;
    logic [RES_W-1:0]  a_na, a_nb;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_v   <= 1'b0;
            a_nl  <= '0;
            a_svc <= '0;
            a_na  <= '0;
            a_nb  <= '0;
        end else if (adv) begin
            a_v   <= 1'b1;
            a_nl  <= nl_cur;
            a_svc <= svc_prod[SPROD_W-1 -: RATE_W];
            a_na  <= rnd[RA_HI -: RES_W];
            a_nb  <= rnd[RB_HI -: RES_W];
        end
    end

    // stage B: scale gap by mean and accumulate arrival time
    logic [GPROD_W-1:0] gap_prod;
    logic [GAP_W-1:0]   gap;
    logic [TIME_W-1:0]  arr_next;
    assign gap_prod = GPROD_W'(mean_gap) * GPROD_W'(a_nl);
    assign gap      = gap_prod[GPROD_W-1:FRAC_W];

    logic              b_v;
    logic [TIME_W-1:0] b_arr;
    logic [RATE_W-1:0] b_svc;
    logic [RES_W-1:0]  b_na, b_nb;

    evgen_sat_add #(.W(TIME_W), .BW(GAP_W)) u_arr_add (
        .a  (b_arr),
        .b  (gap),
        .sum(arr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            b_v   <= 1'b0;
            b_arr <= '0;
            b_svc <= '0;
            b_na  <= '0;
            b_nb  <= '0;
        end else if (adv && a_v) begin
            b_v   <= 1'b1;
            b_arr <= arr_next;
            b_svc <= a_svc;
            b_na  <= a_na;
            b_nb  <= a_nb;
        end
    end

    // stage C: finish time and event placement
    logic [TIME_W-1:0] fin_next;
    evgen_sat_add #(.W(TIME_W), .BW(RATE_W)) u_fin_add (
        .a  (b_arr),
        .b  (b_svc),
        .sum(fin_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_arrival <= '0;
            out_finish  <= '0;
            out_need_a  <= '0;
            out_need_b  <= '0;
        end else if (adv && b_v) begin
            out_valid   <= 1'b1;
            out_arrival <= b_arr;
            out_finish  <= fin_next;
            out_need_a  <= b_na;
            out_need_b  <= b_nb;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{svc_prod[RATE_W-1:0], gap_prod[FRAC_W-1:0]};
endmodule

// File: rtl/evgen_checker.sv
module evgen_checker #(
    parameter int TIME_W = 24,
    parameter int RES_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [TIME_W-1:0] out_arrival,
    input logic [TIME_W-1:0] out_finish,
    input logic [RES_W-1:0]  out_need_a,
    input logic [RES_W-1:0]  out_need_b
);
    logic [1:0]        cyc;
    logic              have_last;
    logic [TIME_W-1:0] last_arr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc       <= '0;
            have_last <= 1'b0;
            last_arr  <= '0;
        end else begin
            if (cyc != 2'd3) cyc <= cyc + 2'd1;
            if (out_valid && out_ready) begin
                have_last <= 1'b1;
                last_arr  <= out_arrival;
            end
        end
    end

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd3) |-> !out_valid);                                   // R7
    AST_STAY_FULL: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3) |-> out_valid);                                    // R7
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_arrival) && $stable(out_finish)
                                       && $stable(out_need_a) && $stable(out_need_b)));  // R8
    AST_FIN_AFTER_ARR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_finish >= out_arrival));                      // R5
    AST_ARR_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && have_last) |-> (out_arrival >= last_arr));         // R4
endmodule

bind rand_event_gen evgen_checker #(
    .TIME_W(TIME_W),
    .RES_W (RES_W)
) u_evgen_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_arrival(out_arrival),
    .out_finish (out_finish),
    .out_need_a (out_need_a),
    .out_need_b (out_need_b)
);

// File: tb/test_rand_event_gen.sv
`timescale 1ns/1ps
module test_rand_event_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mean_gap = '0;
    logic [15:0] svc_span = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [23:0] out_arrival, out_finish;
    logic [3:0]  out_need_a, out_need_b;

    always #2 clk = ~clk;  // 250 MHz

    rand_event_gen i_rand_event_gen (
        .clk        (clk),
        .rst        (rst),
        .mean_gap   (mean_gap),
        .svc_span   (svc_span),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_arrival(out_arrival),
        .out_finish (out_finish),
        .out_need_a (out_need_a),
        .out_need_b (out_need_b)
    );

    typedef struct packed {
        logic [23:0] arr;
        logic [23:0] fin;
        logic [3:0]  na;
        logic [3:0]  nb;
    } exp_t;

    exp_t        scb[$];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    int unsigned lcg    = 32'h1234_5678;

    function automatic logic [31:0] rnd_next(logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    function automatic int nl_of(int i);
        int k;
        k = (i == 0) ? 1 : i;
        return $rtoi(-$ln(real'(k) / 256.0) * 256.0 + 0.5);
    endfunction

    function automatic logic [23:0] sat24(longint v);
        return (v > 64'hFF_FFFF) ? 24'hFF_FFFF : v[23:0];
    endfunction

    // driver: model the segment's events from the requirements and queue them
    task automatic push_segment(logic [15:0] mg, logic [15:0] sp, int n);
        logic [31:0] s;
        longint      acc;
        longint      gap, svc;
        exp_t        e;
        s   = 32'hACE1_2468;  // R1 reseed, R2 state order
        acc = 0;
        for (int k = 0; k < n; k++) begin
            gap   = (longint'(mg) * nl_of(int'(s[31:24]))) >>> 8;     // R3
            acc   = sat24(acc + gap);                                 // R4
            svc   = (longint'(s[15:0]) * longint'(sp)) >>> 16;        // R5
            e.arr = acc[23:0];
            e.fin = sat24(acc + svc);
            e.na  = s[23:20];                                         // R6
            e.nb  = s[19:16];
            scb.push_back(e);
            s = rnd_next(s);
        end
    endtask

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // runs one segment; rdy_pct = percentage of cycles with ready high
    task automatic run_segment(logic [15:0] mg, logic [15:0] sp, int n, int rdy_pct, bit timing_chk);
        int   cyc;
        int   got;
        int   first_v;
        exp_t e;
        @(negedge clk);
        rst       = 1'b1;
        out_ready = 1'b0;
        mean_gap  = mg;
        svc_span  = sp;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid low in reset", out_valid, 0);
        scb.delete();
        push_segment(mg, sp, n);
        rst     = 1'b0;
        cyc     = 0;
        got     = 0;
        first_v = -1;
        while (got < n) begin
            @(negedge clk);
            cyc++;
            lcg       = lcg * 1103515245 + 12345;
            out_ready = (int'(lcg[23:16]) * 100 / 256) < rdy_pct;
            #1;
            if (out_valid && first_v < 0) first_v = cyc;
            if (out_valid && out_ready) begin
                if (scb.size() == 0) begin
                    check(1'b0, "R8 extra event", out_arrival, 0);
                end else begin
                    e = scb.pop_front();
                    check(out_arrival == e.arr, "R3/R4 arrival", out_arrival, e.arr);
                    check(out_finish == e.fin, "R5 finish", out_finish, e.fin);
                    check({out_need_a, out_need_b} == {e.na, e.nb}, "R6 needs",
                          {out_need_a, out_need_b}, {e.na, e.nb});
                end
                got++;
            end
        end
        if (timing_chk) begin
            check(first_v == 3, "R7 first valid cycle", first_v, 3);
            check(got == cyc - 2, "R7 one event per clock", got, cyc - 2);
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        run_segment(16'h0100, 16'h0800, 300, 100, 1'b1);  // steady flow
        run_segment(16'h0480, 16'h1000, 300, 60, 1'b0);   // back-pressure
        run_segment(16'hFFFF, 16'hFFFF, 500, 50, 1'b0);   // saturation under stall
        run_segment(16'h0000, 16'h0000, 60, 70, 1'b0);    // zero rates
        run_segment(16'h0100, 16'h0800, 40, 100, 1'b1);   // repeat after reset: R1
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog expired actual=%0d expected=0 pending", scb.size());
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule